// File: doc/BRIEF.md
# Quadrature Encoder Pulse Counter

This block turns the two phase signals of an incremental encoder into a signed position count. The phase inputs come in already synchronised to the block clock. Each clock edge compares them with the previous sample to find one step up, one step down, or nothing. A two-bit mode selects one of two resolutions. In x4 resolution every phase edge counts. In x2 resolution only edges of phase A count. The mode also selects free-running counting over the full width, or counting bounded by a programmable limit, which suits one mechanical revolution.

Software reaches the block through plain write strobes for the mode, the limit and the counter. It reads these values back on level outputs. A hold register gives a stable copy of the count. It loads on every counter wrap, and on a software strobe. Three sticky flags report a counter wrap, a change of motion direction, and a rising edge on a separate capture input. Each flag is cleared by its own bit of a clear vector. The block moves no data stream, so no port uses valid/ready handshaking. Every pin is a plain control or status level, sampled on each clock edge.

Top module: `quad_pulse_counter`

## Requirements
- R1: After reset the count, hold register and all three flags are 0. The direction output is 1 (up), the mode is 0, the limit is all ones, and the stored phase history is A=0, B=0.
- R2: In x4 resolution each single-phase change moves the count by one. The phase sequence {A,B} = 00, 10, 11, 01, 00 (A leads B) counts up. The reverse sequence counts down.
- R3: A sample in which both phases differ from the stored history changes neither the count nor the direction state. The history still takes the new sample.
- R4: Mode bit 0 set selects x2 resolution. Only changes of A count. The step is up when A and B differ after the change and down when they are equal. Changes of B alone have no effect on the count.
- R5: With mode bit 1 clear (free running), the count wraps from all ones to 0 going up and from 0 to all ones going down. Either wrap sets the counter flag.
- R6: With mode bit 1 set (compare), a step up from a count equal to the limit gives 0. A step down from 0 gives the limit. Either wrap sets the counter flag.
- R7: Each counted step stores its direction on the direction output (1 = up). When that direction differs from the one stored before, the step sets the direction flag.
- R8: On an edge with a counter wrap or a hold strobe, the hold register loads the value the counter takes at that edge.
- R9: A rising edge on the capture input, seen as a high sample after a low one, sets the capture flag.
- R10: The flags are sticky. Clear bit 0 clears the counter flag, bit 1 the direction flag, and bit 2 the capture flag. A flag set and cleared on the same edge ends set.
- R11: A counter write loads the written value. It overrides any step sampled on the same edge, and that step neither changes the direction state nor sets a flag.
- R12: Every output is registered. The effect of an input sample appears on the outputs right after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ph_a | input | 1 | Phase A, synchronised |
| ph_b | input | 1 | Phase B, synchronised |
| cap_in | input | 1 | Capture event input, synchronised |
| mode_we | input | 1 | Mode write strobe |
| mode_wd | input | 2 | Mode value: bit 1 compare, bit 0 x2 |
| lim_we | input | 1 | Limit write strobe |
| lim_wd | input | 16 | Limit value |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wd | input | 16 | Counter value |
| latch_req | input | 1 | Hold register load strobe |
| flag_clr | input | 3 | Flag clear bits (0 counter, 1 direction, 2 capture) |
| mode_q | output | 2 | Current mode |
| lim_q | output | 16 | Current limit |
| cnt_q | output | 16 | Pulse count |
| cnt_hold | output | 16 | Hold register |
| dir_up | output | 1 | Direction of last counted step |
| flag_cnt | output | 1 | Counter wrap flag |
| flag_dir | output | 1 | Direction change flag |
| flag_cap | output | 1 | Capture flag |

## Verification
All results, including the count, hold value, direction, flags and register readback, are due one clock edge after the input sample that causes them. A mode or limit write affects stepping only from the edge after the write. The bench changes inputs one time unit after a rising edge. Before that edge it updates its reference state from those inputs. It compares all outputs one time unit after the edge, so each check lands exactly in the cycle where the result first appears.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  localparam int unsigned NFLAG = 3;
  localparam int unsigned FL_CNT = 0;
  localparam int unsigned FL_DIR = 1;
  localparam int unsigned FL_CAP = 2;

  typedef enum logic [1:0] {
    QM_FREE_X4 = 2'd0,
    QM_FREE_X2 = 2'd1,
    QM_CMP_X4  = 2'd2,
    QM_CMP_X2  = 2'd3
  } qpc_mode_e;

  typedef struct packed {
    logic step;
    logic up;
  } qpc_step_t;
endpackage

// File: rtl/qpc_decoder.sv
module qpc_decoder
  import qpc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ph_a,
  input  logic      ph_b,
  input  logic      x2_sel,
  output qpc_step_t stp
);
  logic prev_a, prev_b;
  logic chg_a, chg_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_a <= 1'b0;
      prev_b <= 1'b0;
    end else begin
      prev_a <= ph_a;
      prev_b <= ph_b;
    end
  end

  always_comb begin
    chg_a    = ph_a ^ prev_a;
    chg_b    = ph_b ^ prev_b;
    // a lone A edge counts up when the phases now differ; a lone B edge when they agree
    stp.up   = chg_a ? (ph_a ^ ph_b) : ~(ph_a ^ ph_b);
    stp.step = x2_sel ? (chg_a & ~chg_b) : (chg_a ^ chg_b);
  end
endmodule

// File: rtl/qpc_counter.sv
module qpc_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          up,
  input  logic          cmp_en,
  input  logic [CW-1:0] limit,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt,
  output logic          wrap
);
  localparam logic [CW-1:0] ALL1 = '1;

  always_comb begin
    count_nxt = count;
    wrap      = 1'b0;
    if (wr) begin
      count_nxt = wdata;
    end else if (step) begin
      if (up) begin
        if (cmp_en && count == limit) begin
          count_nxt = '0;
          wrap      = 1'b1;
        end else begin
          count_nxt = count + 1'b1;
          wrap      = !cmp_en && count == ALL1;
        end
      end else begin
        wrap = (count == '0);
        if (cmp_en && count == '0) count_nxt = limit;
        else                       count_nxt = count - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end
endmodule

// File: rtl/qpc_flags.sv
module qpc_flags #(
  parameter int unsigned NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set,
  input  logic [NF-1:0] clr,
  output logic [NF-1:0] flags
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/quad_pulse_counter.sv
module quad_pulse_counter
  import qpc_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ph_a,
  input  logic          ph_b,
  input  logic          cap_in,
  input  logic          mode_we,
  input  logic [1:0]    mode_wd,
  input  logic          lim_we,
  input  logic [CW-1:0] lim_wd,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_wd,
  input  logic          latch_req,
  input  logic [2:0]    flag_clr,
  output logic [1:0]    mode_q,
  output logic [CW-1:0] lim_q,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_hold,
  output logic          dir_up,
  output logic          flag_cnt,
  output logic          flag_dir,
  output logic          flag_cap
);
  qpc_mode_e      mode_r;
  qpc_step_t      dec_stp;
  logic           dec_step, dec_up, step_taken;
  logic [CW-1:0]  cnt_next;
  logic           cnt_wrap;
  logic           cap_prev;
  logic [NFLAG-1:0] fl_set, fl_q;

  assign dec_step   = dec_stp.step;
  assign dec_up     = dec_stp.up;
  assign step_taken = dec_step & ~cnt_we;

  qpc_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .ph_a(ph_a), .ph_b(ph_b),
    .x2_sel(mode_r[0]), .stp(dec_stp)
  );

  qpc_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(dec_step), .up(dec_up),
    .cmp_en(mode_r[1]), .limit(lim_q), .wr(cnt_we), .wdata(cnt_wd),
    .count(cnt_q), .count_nxt(cnt_next), .wrap(cnt_wrap)
  );

  always_comb begin
    fl_set         = '0;
    fl_set[FL_CNT] = cnt_wrap;
    fl_set[FL_DIR] = step_taken & (dec_up != dir_up);
    fl_set[FL_CAP] = cap_in & ~cap_prev;
  end

  qpc_flags #(.NF(NFLAG)) u_flg (
    .clk(clk), .rst_n(rst_n), .set(fl_set), .clr(flag_clr), .flags(fl_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_r   <= QM_FREE_X4;
      lim_q    <= '1;
      cnt_hold <= '0;
      dir_up   <= 1'b1;
      cap_prev <= 1'b0;
    end else begin
      if (mode_we)               mode_r   <= qpc_mode_e'(mode_wd);
      if (lim_we)                lim_q    <= lim_wd;
      if (cnt_wrap || latch_req) cnt_hold <= cnt_next;
      if (step_taken)            dir_up   <= dec_up;
      cap_prev <= cap_in;
    end
  end

  assign mode_q   = mode_r;
  assign flag_cnt = fl_q[FL_CNT];
  assign flag_dir = fl_q[FL_DIR];
  assign flag_cap = fl_q[FL_CAP];
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ph_a,
  input logic          ph_b,
  input logic          cap_in,
  input logic          cnt_we,
  input logic          latch_req,
  input logic [1:0]    mode_q,
  input logic [CW-1:0] lim_q,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] cnt_hold,
  input logic          flag_cnt,
  input logic          flag_cap,
  input logic          dec_step,
  input logic          dec_up
);
  localparam logic [CW-1:0] ALL1 = '1;
  logic seen_a, seen_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_a <= 1'b0;
      seen_b <= 1'b0;
    end else begin
      seen_a <= ph_a;
      seen_b <= ph_b;
    end
  end

  p_illegal_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_a != seen_a) && (ph_b != seen_b) && !cnt_we) |=> cnt_q == $past(cnt_q));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_step && !cnt_we) |=> cnt_q == $past(cnt_q));

  p_cmp_wrap_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1] && dec_step && dec_up && !cnt_we && cnt_q == lim_q) |=> cnt_q == '0);

  p_cmp_wrap_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1] && dec_step && !dec_up && !cnt_we && cnt_q == '0) |=> cnt_q == $past(lim_q));

  p_cnt_flag_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_cnt) |-> ($past(cnt_q) == '0 || $past(cnt_q) == ALL1 || $past(cnt_q) == $past(lim_q)));

  p_strobe_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    latch_req |=> cnt_hold == cnt_q);

  p_cap_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_cap) |-> $past(cap_in));
endmodule

bind quad_pulse_counter qpc_checker #(.CW(CW)) u_qpc_chk (
  .clk(clk), .rst_n(rst_n), .ph_a(ph_a), .ph_b(ph_b), .cap_in(cap_in),
  .cnt_we(cnt_we), .latch_req(latch_req), .mode_q(mode_q), .lim_q(lim_q),
  .cnt_q(cnt_q), .cnt_hold(cnt_hold), .flag_cnt(flag_cnt), .flag_cap(flag_cap),
  .dec_step(dec_step), .dec_up(dec_up)
);

// File: tb/test_quad_pulse_counter.sv
module test_quad_pulse_counter;
  localparam int CLK_P = 10;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ph_a = 0, ph_b = 0, cap_in = 0;
  logic mode_we = 0, lim_we = 0, cnt_we = 0, latch_req = 0;
  logic [1:0] mode_wd = 0;
  logic [CW-1:0] lim_wd = 0, cnt_wd = 0;
  logic [2:0] flag_clr = 0;
  logic [1:0] mode_q;
  logic [CW-1:0] lim_q, cnt_q, cnt_hold;
  logic dir_up, flag_cnt, flag_dir, flag_cap;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int g = 0;

  logic [CW-1:0] m_cnt, m_lat, m_lim;
  logic [1:0] m_mode;
  logic m_dir, m_fc, m_fd, m_fp, m_pa, m_pb, m_cap;

  always #(CLK_P/2) clk = ~clk;

  quad_pulse_counter #(.CW(CW)) i_quad_pulse_counter (.*);

  function automatic int gidx(logic a, logic b);
    case ({a, b})
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  // returns {counted, up}
  function automatic logic [1:0] f_dec(logic pa, logic pb, logic a, logic b, logic x2);
    int d = (gidx(a, b) - gidx(pa, pb) + 4) % 4;
    logic leg = (d == 1) || (d == 3);
    logic cnt = x2 ? (leg && (a != pa)) : leg;
    return {cnt, d == 1};
  endfunction

  function automatic logic [CW:0] f_next(logic [CW-1:0] c, logic up, logic cmp, logic [CW-1:0] lim);
    logic [CW-1:0] top = cmp ? lim : {CW{1'b1}};
    if (up) return (c == top) ? {1'b1, {CW{1'b0}}} : {1'b0, c + 16'd1};
    return (c == 0) ? {1'b1, top} : {1'b0, c - 16'd1};
  endfunction

  task automatic m_reset();
    m_cnt = 0; m_lat = 0; m_lim = '1; m_mode = 0; m_dir = 1;
    m_fc = 0; m_fd = 0; m_fp = 0; m_pa = 0; m_pb = 0; m_cap = 0;
  endtask

  task automatic m_step();
    logic [1:0] s = f_dec(m_pa, m_pb, ph_a, ph_b, m_mode[0]);
    logic taken = s[1] && !cnt_we;
    logic [CW:0] r = f_next(m_cnt, s[0], m_mode[1], m_lim);
    logic wr = taken && r[CW];
    logic [CW-1:0] nc = cnt_we ? cnt_wd : (taken ? r[CW-1:0] : m_cnt);
    logic sd = taken && (s[0] != m_dir);
    logic sp = cap_in && !m_cap;
    m_fc = wr || (m_fc && !flag_clr[0]);
    m_fd = sd || (m_fd && !flag_clr[1]);
    m_fp = sp || (m_fp && !flag_clr[2]);
    if (taken) m_dir = s[0];
    if (wr || latch_req) m_lat = nc;
    m_cnt = nc;
    if (mode_we) m_mode = mode_wd;
    if (lim_we) m_lim = lim_wd;
    m_pa = ph_a; m_pb = ph_b; m_cap = cap_in;
  endtask

  task automatic chk_val(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    m_step();
    @(posedge clk); #1;
    chk_val(tag, {cnt_q, cnt_hold, lim_q, mode_q, dir_up, flag_cnt, flag_dir, flag_cap},
                 {m_cnt, m_lat, m_lim, m_mode, m_dir, m_fc, m_fd, m_fp});
    mode_we = 0; lim_we = 0; cnt_we = 0; latch_req = 0; flag_clr = 0;
  endtask

  task automatic mv(int d, string tag);
    g = (g + d + 4) % 4;
    case (g)
      0: {ph_a, ph_b} = 2'b00;
      1: {ph_a, ph_b} = 2'b10;
      2: {ph_a, ph_b} = 2'b11;
      default: {ph_a, ph_b} = 2'b01;
    endcase
    tick(tag);
  endtask

  task automatic set_mode(logic [1:0] m);
    mode_we = 1; mode_wd = m; tick("R4 mode write");
  endtask

  task automatic set_cnt(logic [CW-1:0] v, string tag);
    cnt_we = 1; cnt_wd = v; tick(tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int s = $urandom(1234);
    repeat (3) @(posedge clk);
    #1; rst_n = 1; m_reset();
    chk_val("R1 reset", {cnt_q, cnt_hold, lim_q, mode_q, dir_up, flag_cnt, flag_dir, flag_cap},
            {16'd0, 16'd0, 16'hFFFF, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0});
    // R2 x4 counting
    for (int i = 0; i < 4; i++) mv(1, "R2 up");
    chk_val("R2 four up", cnt_q, 4);
    mv(-1, "R2 down"); mv(-1, "R7 reversal");
    chk_val("R2 two down", cnt_q, 2);
    chk_val("R7 dir flag", {flag_dir, dir_up}, 2'b10);
    flag_clr = 3'b010; tick("R10 clear dir");
    chk_val("R10 cleared", flag_dir, 0);
    // R3 illegal
    mv(2, "R3 illegal");
    chk_val("R3 no count", cnt_q, 2);
    // R4 x2
    set_mode(2'd1);
    for (int i = 0; i < 4; i++) mv(1, "R4 x2 up");
    chk_val("R4 x2 count", cnt_q, 4);
    // R5 free wrap
    set_mode(2'd0);
    set_cnt(0, "R11 write");
    mv(-1, "R5 wrap down");
    chk_val("R5 wrap", {cnt_q, flag_cnt, cnt_hold}, {16'hFFFF, 1'b1, 16'hFFFF});
    mv(1, "R5 wrap up");
    chk_val("R5 wrap up", cnt_q, 0);
    // R6 compare
    set_mode(2'd2);
    lim_we = 1; lim_wd = 5; tick("R6 limit");
    flag_clr = 3'b001; tick("R10 clear cnt");
    set_cnt(4, "R11 write 4");
    mv(1, "R6 to limit"); mv(1, "R6 wrap up");
    chk_val("R6 cmp wrap up", {cnt_q, flag_cnt, cnt_hold}, {16'd0, 1'b1, 16'd0});
    mv(-1, "R6 wrap down");
    chk_val("R6 cmp wrap down", cnt_q, 5);
    // R8 strobe
    mv(-1, "R6 down"); latch_req = 1; tick("R8 strobe");
    chk_val("R8 hold", cnt_hold, 4);
    // R9/R10 capture, set beats clear
    cap_in = 1; flag_clr = 3'b100; tick("R9 capture");
    chk_val("R10 set wins", flag_cap, 1);
    cap_in = 0; flag_clr = 3'b100; tick("R10 clear cap");
    // R11 write overrides step
    cnt_we = 1; cnt_wd = 16'h0033; g = (g + 1) % 4;
    {ph_a, ph_b} = (g == 0) ? 2'b00 : (g == 1) ? 2'b10 : (g == 2) ? 2'b11 : 2'b01;
    tick("R11 override");
    chk_val("R11 value", cnt_q, 16'h0033);
    // random
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 16;
      if ($urandom % 64 == 0) begin mode_we = 1; mode_wd = 2'($urandom); end
      if ($urandom % 64 == 0) begin lim_we = 1; lim_wd = 16'($urandom % 12); end
      if ($urandom % 128 == 0) begin cnt_we = 1; cnt_wd = 16'($urandom); end
      if ($urandom % 32 == 0) latch_req = 1;
      if ($urandom % 16 == 0) flag_clr = 3'($urandom);
      cap_in = ($urandom % 8 == 0);
      if (r < 7) mv(1, "R12 random");
      else if (r < 12) mv(-1, "R12 random");
      else if (r == 12) mv(2, "R3 random");
      else tick("R12 random");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule